// File: doc/BRIEF.md
# Sync Clock Detector and Cycle-Start Selector

This block decides where each switching cycle of a regulator begins. It runs on a fast reference clock and watches an external, active-low synchronization input. It measures the time between falling edges of that input. When the input toggles fast enough, every falling edge, delayed by a fixed count of reference clocks, starts a switching cycle. When the input is static or too slow, a free-running internal divider sets both the frequency and the phase of the cycles.

The output is a one-clock cycle-start strobe and a flag that shows which source drives it. The source changes only on a cycle boundary of the source being switched to. A switch needs two qualifying periods in a row, and a switch back needs two failing periods in a row. With the default parameters and a 100 MHz reference, the internal cadence is 1 MHz and the threshold is about 300 kHz.

Top module: `sync_cycle_sel`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `cycle_start` is 0 and `ext_active` is 0.
- R2: With `sync_n` held high, `cycle_start` is a one-clock pulse that repeats every INT_PERIOD (100) reference clocks.
- R3: While the internal source is selected, falling edges that do not qualify leave the internal cadence of INT_PERIOD clocks unchanged. Rising edges of `sync_n` carry no meaning.
- R4: A period between two sampled falling edges qualifies only if it is at most MAX_PERIOD (333) clocks. A period of MAX_PERIOD+1 or more fails. A gap of more than MAX_PERIOD clocks with no edge counts as one failing period for each MAX_PERIOD+1 clocks. The first edge after such a gap, or after reset, only arms the measurement.
- R5: Starting from internal mode, `ext_active` becomes 1 after the second qualifying period in a row. The change happens at the strobe derived from the edge that completes that second period, which is the third edge after idle.
- R6: In external mode, `cycle_start` is high in the clock that follows rising edge number EXT_DELAY+1 (11), counting the first rising edge that samples `sync_n` low as edge 0.
- R7: In external mode, with periods from 80 to 333 clocks, exactly one strobe is produced per falling edge and no internal strobes are produced.
- R8: A single failing period in external mode leaves `ext_active` at 1. The block returns to internal mode only after two failing periods in a row.
- R9: `ext_active` changes only in a cycle where `cycle_start` is high. After a return to internal mode, the first internal strobe comes a whole multiple of INT_PERIOD clocks after the last external strobe, and the cadence of INT_PERIOD clocks follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | External active-low synchronization input, asynchronous |
| cycle_start | output | 1 | One-clock strobe at the start of each switching cycle |
| ext_active | output | 1 | 1 when cycles follow the external input, 0 for the internal divider |

## Verification
The hardest case to reach is the return from external to internal mode. It depends on two timeouts in a row, and the switch must land on an internal boundary that stays phase-aligned to the last external strobe. The bench gets there by stopping the input after a run of edges. It checks that the flag holds through the first timeout, then measures the gap from the last external strobe to the first internal one. A one-clock boundary test with periods of 333 and 334 clocks, and a single long gap inside an external run, separate the qualification threshold from the hysteresis.

// File: rtl/sync_cycle_sel_pkg.sv
package sync_cycle_sel_pkg;

  // A period whose count of elapsed clocks minus one is below limit qualifies.
  function automatic logic period_ok(input int elapsed_m1, input int limit);
    return elapsed_m1 < limit;
  endfunction

  // Saturating run-length increment.
  function automatic int run_inc(input int run, input int cap);
    return (run >= cap) ? cap : run + 1;
  endfunction

endpackage

// File: rtl/sync_edge_path.sv
module sync_edge_path #(
  parameter int SYNC_STAGES = 2,
  parameter int EXT_DELAY   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n_i,
  output logic fall_o,
  output logic ext_pulse_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic [EXT_DELAY-1:0]   dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
      dly_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], sync_n_i};
      last_q <= sync_q[SYNC_STAGES-1];
      dly_q  <= {dly_q[EXT_DELAY-2:0], fall_o};
    end
  end

  assign fall_o      = last_q & ~sync_q[SYNC_STAGES-1];
  assign ext_pulse_o = dly_q[EXT_DELAY-1];

  AST_FALL_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R3
endmodule

// File: rtl/sync_period_meter.sv
module sync_period_meter
  import sync_cycle_sel_pkg::*;
#(
  parameter int MAX_PERIOD = 333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  output logic good_o,
  output logic bad_o
);
  localparam int CW = $clog2(MAX_PERIOD + 1);

  logic [CW-1:0] cnt_q;
  logic          stale_q;
  logic          timeout;

  assign timeout = !fall_i && (int'(cnt_q) == MAX_PERIOD);
  assign good_o  = fall_i && !stale_q && period_ok(int'(cnt_q), MAX_PERIOD);
  assign bad_o   = timeout || (fall_i && !stale_q && !period_ok(int'(cnt_q), MAX_PERIOD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stale_q <= 1'b1;
    end else if (fall_i) begin
      cnt_q   <= '0;
      stale_q <= 1'b0;
    end else if (timeout) begin
      cnt_q   <= '0;
      stale_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= MAX_PERIOD); // R4
  AST_ARMED_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_i |=> !stale_q); // R4
endmodule

// File: rtl/sync_source_arb.sv
module sync_source_arb
  import sync_cycle_sel_pkg::*;
#(
  parameter int INT_PERIOD = 100,
  parameter int QUAL_RUN   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic good_i,
  input  logic bad_i,
  input  logic ext_pulse_i,
  output logic cycle_start_o,
  output logic ext_active_o
);
  localparam int DW = $clog2(INT_PERIOD);
  localparam int RW = $clog2(QUAL_RUN + 1);

  logic [DW-1:0] div_q;
  logic [RW-1:0] good_run_q, bad_run_q;
  logic          want_q, sel_q;
  logic          int_pulse, switch_now;

  assign int_pulse = (int'(div_q) == INT_PERIOD - 1);
  assign cycle_start_o = sel_q ? (ext_pulse_i | (!want_q & int_pulse))
                               : (int_pulse | (want_q & ext_pulse_i));
  assign switch_now = (sel_q != want_q) && (want_q ? ext_pulse_i : int_pulse);
  assign ext_active_o = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q      <= '0;
      good_run_q <= '0;
      bad_run_q  <= '0;
      want_q     <= 1'b0;
      sel_q      <= 1'b0;
    end else begin
      div_q <= (cycle_start_o || int_pulse) ? '0 : div_q + 1'b1;
      if (switch_now) sel_q <= want_q;
      if (good_i) begin
        good_run_q <= RW'(run_inc(int'(good_run_q), QUAL_RUN));
        bad_run_q  <= '0;
        if (run_inc(int'(good_run_q), QUAL_RUN) >= QUAL_RUN) want_q <= 1'b1;
      end else if (bad_i) begin
        bad_run_q  <= RW'(run_inc(int'(bad_run_q), QUAL_RUN));
        good_run_q <= '0;
        if (run_inc(int'(bad_run_q), QUAL_RUN) >= QUAL_RUN) want_q <= 1'b0;
      end
    end
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(div_q) < INT_PERIOD); // R2
  AST_SRC_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(cycle_start_o)); // R9
  AST_WANT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(want_q) |-> $past(good_i)); // R5
  AST_WANT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(want_q) |-> $past(bad_i)); // R8
endmodule

// File: rtl/sync_cycle_sel.sv
module sync_cycle_sel #(
  parameter int INT_PERIOD  = 100,
  parameter int MAX_PERIOD  = 333,
  parameter int EXT_DELAY   = 10,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_RUN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  output logic cycle_start,
  output logic ext_active
);
  logic fall_evt, ext_pulse, verdict_good, verdict_bad;

  sync_edge_path #(.SYNC_STAGES(SYNC_STAGES), .EXT_DELAY(EXT_DELAY)) u_edge (
    .clk(clk), .rst_n(rst_n), .sync_n_i(sync_n),
    .fall_o(fall_evt), .ext_pulse_o(ext_pulse));

  sync_period_meter #(.MAX_PERIOD(MAX_PERIOD)) u_meter (
    .clk(clk), .rst_n(rst_n), .fall_i(fall_evt),
    .good_o(verdict_good), .bad_o(verdict_bad));

  sync_source_arb #(.INT_PERIOD(INT_PERIOD), .QUAL_RUN(QUAL_RUN)) u_arb (
    .clk(clk), .rst_n(rst_n), .good_i(verdict_good), .bad_i(verdict_bad),
    .ext_pulse_i(ext_pulse), .cycle_start_o(cycle_start), .ext_active_o(ext_active));

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(verdict_good && verdict_bad)); // R4
endmodule

// File: tb/sync_cycle_sel_tb.sv
module sync_cycle_sel_tb;
  localparam int INT_P = 100;
  localparam int DLY   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1;
  logic cycle_start, ext_active;

  int errors = 0, checks = 0;
  int cyc = 0, strobe_cnt = 0, last_strobe_cyc = 0, last_gap = 0;
  int first_gap = 0, mark = -5, last_edge_cyc = 0;

  always #5 clk = ~clk;

  sync_cycle_sel u_dut (.clk(clk), .rst_n(rst_n), .sync_n(sync_n),
                        .cycle_start(cycle_start), .ext_active(ext_active));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && cycle_start) begin
      last_gap = cyc - last_strobe_cyc;
      last_strobe_cyc = cyc;
      strobe_cnt = strobe_cnt + 1;
      if (strobe_cnt == mark + 1) first_gap = last_gap;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_edges(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sync_n = 1'b0;
      last_edge_cyc = cyc + 1;
      repeat (20) @(negedge clk);
      sync_n = 1'b1;
      repeat (period - 21) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check(cycle_start == 1'b0, "R1 strobe in reset", cycle_start, 0);
    check(ext_active == 1'b0, "R1 flag in reset", ext_active, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(cycle_start == 1'b0, "R1 strobe after reset", cycle_start, 0);
    check(ext_active == 1'b0, "R1 flag after reset", ext_active, 0);
  endtask

  task automatic t_internal();
    repeat (350) @(negedge clk);
    check(last_gap == INT_P, "R2 internal cadence", last_gap, INT_P);
    check(ext_active == 1'b0, "R2 internal selected", ext_active, 0);
  endtask

  task automatic t_slow();
    send_edges(5, 400);
    check(ext_active == 1'b0, "R4 slow input rejected", ext_active, 0);
    check(last_gap == INT_P, "R3 slow edges leave cadence", last_gap, INT_P);
    send_edges(5, 334);
    check(ext_active == 1'b0, "R4 period 334 rejected", ext_active, 0);
    repeat (1000) @(negedge clk);
  endtask

  task automatic t_switch();
    send_edges(2, 333);
    check(ext_active == 1'b0, "R5 one good period not enough", ext_active, 0);
    send_edges(1, 333);
    check(ext_active == 1'b1, "R5 switch after two good periods", ext_active, 1);
    check(last_strobe_cyc - last_edge_cyc == DLY + 1, "R6 latency at switch",
          last_strobe_cyc - last_edge_cyc, DLY + 1);
  endtask

  task automatic t_ext_run();
    int s0;
    s0 = strobe_cnt;
    send_edges(10, 80);
    check(strobe_cnt - s0 == 10, "R7 one strobe per edge at 80", strobe_cnt - s0, 10);
    check(last_strobe_cyc - last_edge_cyc == DLY + 1, "R6 latency in run",
          last_strobe_cyc - last_edge_cyc, DLY + 1);
    s0 = strobe_cnt;
    send_edges(4, 300);
    check(strobe_cnt - s0 == 4, "R7 one strobe per edge at 300", strobe_cnt - s0, 4);
    check(ext_active == 1'b1, "R7 still external", ext_active, 1);
  endtask

  task automatic t_hysteresis();
    send_edges(1, 450);
    send_edges(3, 80);
    check(ext_active == 1'b1, "R8 single long gap keeps external", ext_active, 1);
  endtask

  task automatic t_fallback();
    mark = strobe_cnt;
    repeat (400) @(negedge clk);
    check(ext_active == 1'b1, "R8 one timeout keeps external", ext_active, 1);
    repeat (1200) @(negedge clk);
    check(ext_active == 1'b0, "R8 two timeouts return to internal", ext_active, 0);
    check(first_gap > 0 && first_gap % INT_P == 0, "R9 first internal strobe aligned",
          first_gap, (first_gap / INT_P) * INT_P);
    check(last_gap == INT_P, "R9 internal cadence resumes", last_gap, INT_P);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    t_internal();
    t_slow();
    t_switch();
    t_ext_run();
    t_hysteresis();
    t_fallback();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule